// File: doc/BRIEF.md
# Subroutine and Interrupt Return Unit

This unit executes the two return instructions of a small 8-bit controller core. It decodes each offered 16-bit instruction word. On either return opcode it pops the hardware return-address stack and hands the popped address to the program counter. The interrupt return also re-arms the global enable of the level being left. When its fast flag is set, it also copies the shadow W, STATUS and bank-select values back. The literal return puts its 8-bit operand in W, which lets a computed jump into a run of such instructions serve as a lookup table.

The unit owns the return-address stack and the three shadow registers. Interrupt entry pushes its return address and captures the shadow registers in one and the same cycle. A return that is accepted takes two instruction cycles. Its results appear as one-cycle load strobes in the cycle after acceptance, and that cycle is the idle second cycle, marked by `busy`. One clock period stands for one instruction cycle, so phases Q1 to Q4 all fall inside it.

Top module: `returnUnit`

## Requirements
- R1: The word 0x0010 or 0x0011 (bits 15..1 equal 0000_0000_0001_000, bit 0 the fast flag) is an interrupt return. Once accepted, the cycle after acceptance shows `pcLoad` high for one cycle, with `pcValue` equal to the most recently pushed address that is still on the stack, and `stackDepth` one lower.
- R2: The word 0x0C00 plus k (bits 15..8 equal 0x0C, k in bits 7..0) is a literal return. It pops the stack like R1 and pulses `wLoad` with `wValue` = k, and it leaves `statusLoad`, `bsrLoad` and both enable strobes low.
- R3: A return is accepted when `instrValid` is high, `busy` is low and `intEntry` is low. `busy` is high in the cycle after acceptance, and an instruction offered while `busy` is high has no effect.
- R4: An interrupt return with bit 0 = 1 pulses `wLoad`, `statusLoad` and `bsrLoad` together with the shadow contents. With bit 0 = 0, none of the three strobes rises.
- R5: When `intEntry` is high, the shadow registers take `wCur`, `statusCur` and `bsrCur` on that edge. They hold those values until the next entry, whatever returns are executed in between.
- R6: An entry with `intEntryHigh` = 1 marks a high-level interrupt as active. An interrupt return pulses `gieHighSet` and clears the mark if it is set, and otherwise pulses `gieLowSet`. At most one of the two is ever high.
- R7: The stack holds up to DEPTH (31) addresses in last-in first-out order, and `stackDepth` reports the number held.
- R8: A push while the stack is full discards the address, keeps the contents and depth, and sets the sticky `stackOverflow` until reset.
- R9: A pop of an empty stack gives `pcValue` = 0, keeps the depth at 0, and sets the sticky `stackUnderflow` until reset.
- R10: When `intEntry` and an acceptable return fall in the same cycle, the entry is carried out and the return is dropped: no strobe, no pop, and no `busy`.
- R11: Any other instruction word leaves all strobes, `busy` and the stack untouched.
- R12: After reset all strobes, `busy`, both sticky flags and `stackDepth` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | `instrWord` holds an instruction to execute |
| instrWord | input | 16 | Instruction word |
| intEntry | input | 1 | Interrupt entry: push address and capture shadows |
| intEntryHigh | input | 1 | The entered interrupt is of the high level |
| intReturnAddr | input | PC_W (21) | Return address pushed on entry |
| wCur | input | 8 | Current W, captured on entry |
| statusCur | input | STATUS_W (5) | Current STATUS, captured on entry |
| bsrCur | input | BSR_W (4) | Current bank select, captured on entry |
| busy | output | 1 | Second, idle cycle of a return |
| pcLoad | output | 1 | Load `pcValue` into the program counter |
| pcValue | output | PC_W (21) | Popped return address |
| wLoad | output | 1 | Load `wValue` into W |
| wValue | output | 8 | New W value |
| statusLoad | output | 1 | Load `statusValue` into STATUS |
| statusValue | output | STATUS_W (5) | New STATUS value |
| bsrLoad | output | 1 | Load `bsrValue` into bank select |
| bsrValue | output | BSR_W (4) | New bank select value |
| gieHighSet | output | 1 | Set the high-level global interrupt enable |
| gieLowSet | output | 1 | Set the low-level global interrupt enable |
| stackDepth | output | PTR_W (5) | Addresses held on the stack |
| stackOverflow | output | 1 | Sticky: push on a full stack |
| stackUnderflow | output | 1 | Sticky: pop on an empty stack |

## Verification
Interrupt entry and a return compete for the one stack port and the shadow registers. The bench raises `intEntry` in the same cycle that a literal return is offered. It then expects the return to be dropped, the new address to be on top and the depth one higher. A second literal return must then pop exactly that address. The bench also raises an entry during a return's `busy` cycle, where the entry must land normally. The stack sweep, the literal sweep and the fast-restore sweep compare every popped address, literal and restored value against a stack model and values computed in the bench.

// File: rtl/returnUnitPkg.sv
package returnUnitPkg;

  typedef struct packed {
    logic pop;
    logic push;
    logic captureShadow;
    logic restoreShadow;
    logic loadLiteral;
    logic setHigh;
    logic setLow;
  } retStrobeT;

  function automatic logic isIntReturn(input logic [15:0] word);
    return word[15:1] == 15'b0000_0000_0001_000;
  endfunction

  function automatic logic isLitReturn(input logic [15:0] word);
    return word[15:8] == 8'h0C;
  endfunction

endpackage

// File: rtl/returnCtrl.sv
module returnCtrl
  import returnUnitPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [15:0] instrWord,
  input  logic        intEntry,
  input  logic        intEntryHigh,
  output retStrobeT   strobe,
  output logic        busy
);

  logic decInt;
  logic decLit;
  logic accept;
  logic busyQ;
  logic highActive;

  always_comb begin
    decInt = isIntReturn(instrWord);
    decLit = isLitReturn(instrWord);
    // entry has the stack port this cycle; a return offered now is dropped
    accept = instrValid && !busyQ && !intEntry && (decInt || decLit);

    strobe               = '0;
    strobe.push          = intEntry;
    strobe.captureShadow = intEntry;
    strobe.pop           = accept;
    strobe.loadLiteral   = accept && decLit;
    strobe.restoreShadow = accept && decInt && instrWord[0];
    strobe.setHigh       = accept && decInt && highActive;
    strobe.setLow        = accept && decInt && !highActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ      <= 1'b0;
      highActive <= 1'b0;
    end else begin
      busyQ <= accept;
      if (intEntry && intEntryHigh) begin
        highActive <= 1'b1;
      end else if (strobe.setHigh) begin
        highActive <= 1'b0;
      end
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/returnDatapath.sv
module returnDatapath
  import returnUnitPkg::*;
#(
  parameter int PC_W     = 21,
  parameter int DEPTH    = 31,
  parameter int DATA_W   = 8,
  parameter int STATUS_W = 5,
  parameter int BSR_W    = 4,
  localparam int PTR_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  retStrobeT           strobe,
  input  logic [DATA_W-1:0]   literal,
  input  logic [PC_W-1:0]     pushAddr,
  input  logic [DATA_W-1:0]   wCur,
  input  logic [STATUS_W-1:0] statusCur,
  input  logic [BSR_W-1:0]    bsrCur,
  output logic                pcLoad,
  output logic [PC_W-1:0]     pcValue,
  output logic                wLoad,
  output logic [DATA_W-1:0]   wValue,
  output logic                statusLoad,
  output logic [STATUS_W-1:0] statusValue,
  output logic                bsrLoad,
  output logic [BSR_W-1:0]    bsrValue,
  output logic                gieHighSet,
  output logic                gieLowSet,
  output logic [PTR_W-1:0]    stackDepth,
  output logic                stackOverflow,
  output logic                stackUnderflow
);

  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  logic [PC_W-1:0]     entryQ [DEPTH];
  logic [PTR_W-1:0]    ptrQ;
  logic [PTR_W-1:0]    topIdx;
  logic                isFull;
  logic                isEmpty;
  logic [PC_W-1:0]     topAddr;
  logic [DATA_W-1:0]   shadowW;
  logic [STATUS_W-1:0] shadowStatus;
  logic [BSR_W-1:0]    shadowBsr;

  always_comb begin
    isFull  = (ptrQ == FULL);
    isEmpty = (ptrQ == '0);
    topIdx  = ptrQ - 1'b1;
    topAddr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (topIdx == PTR_W'(i)) topAddr = entryQ[i];
    end
  end

  // one register per stack slot, written only when it is the next free slot
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strobe.push && !isFull && ptrQ == PTR_W'(g)) begin
        entryQ[g] <= pushAddr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ           <= '0;
      stackOverflow  <= 1'b0;
      stackUnderflow <= 1'b0;
      pcLoad         <= 1'b0;
      pcValue        <= '0;
    end else begin
      pcLoad <= strobe.pop;
      if (strobe.push) begin
        if (isFull) stackOverflow <= 1'b1;
        else        ptrQ <= ptrQ + 1'b1;
      end else if (strobe.pop) begin
        if (isEmpty) begin
          pcValue        <= '0;
          stackUnderflow <= 1'b1;
        end else begin
          pcValue <= topAddr;
          ptrQ    <= topIdx;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowW      <= '0;
      shadowStatus <= '0;
      shadowBsr    <= '0;
    end else if (strobe.captureShadow) begin
      shadowW      <= wCur;
      shadowStatus <= statusCur;
      shadowBsr    <= bsrCur;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wLoad       <= 1'b0;
      wValue      <= '0;
      statusLoad  <= 1'b0;
      statusValue <= '0;
      bsrLoad     <= 1'b0;
      bsrValue    <= '0;
      gieHighSet  <= 1'b0;
      gieLowSet   <= 1'b0;
    end else begin
      wLoad      <= strobe.loadLiteral || strobe.restoreShadow;
      statusLoad <= strobe.restoreShadow;
      bsrLoad    <= strobe.restoreShadow;
      gieHighSet <= strobe.setHigh;
      gieLowSet  <= strobe.setLow;
      if (strobe.loadLiteral) begin
        wValue <= literal;
      end else if (strobe.restoreShadow) begin
        wValue <= shadowW;
      end
      if (strobe.restoreShadow) begin
        statusValue <= shadowStatus;
        bsrValue    <= shadowBsr;
      end
    end
  end

  assign stackDepth = ptrQ;

endmodule

// File: rtl/returnUnit.sv
module returnUnit
  import returnUnitPkg::*;
#(
  parameter int PC_W     = 21,
  parameter int DEPTH    = 31,
  parameter int STATUS_W = 5,
  parameter int BSR_W    = 4,
  localparam int PTR_W   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instrValid,
  input  logic [15:0]         instrWord,
  input  logic                intEntry,
  input  logic                intEntryHigh,
  input  logic [PC_W-1:0]     intReturnAddr,
  input  logic [7:0]          wCur,
  input  logic [STATUS_W-1:0] statusCur,
  input  logic [BSR_W-1:0]    bsrCur,
  output logic                busy,
  output logic                pcLoad,
  output logic [PC_W-1:0]     pcValue,
  output logic                wLoad,
  output logic [7:0]          wValue,
  output logic                statusLoad,
  output logic [STATUS_W-1:0] statusValue,
  output logic                bsrLoad,
  output logic [BSR_W-1:0]    bsrValue,
  output logic                gieHighSet,
  output logic                gieLowSet,
  output logic [PTR_W-1:0]    stackDepth,
  output logic                stackOverflow,
  output logic                stackUnderflow
);

  retStrobeT strobe;

  returnCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .instrValid   (instrValid),
    .instrWord    (instrWord),
    .intEntry     (intEntry),
    .intEntryHigh (intEntryHigh),
    .strobe       (strobe),
    .busy         (busy)
  );

  returnDatapath #(
    .PC_W     (PC_W),
    .DEPTH    (DEPTH),
    .DATA_W   (8),
    .STATUS_W (STATUS_W),
    .BSR_W    (BSR_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .literal        (instrWord[7:0]),
    .pushAddr       (intReturnAddr),
    .wCur           (wCur),
    .statusCur      (statusCur),
    .bsrCur         (bsrCur),
    .pcLoad         (pcLoad),
    .pcValue        (pcValue),
    .wLoad          (wLoad),
    .wValue         (wValue),
    .statusLoad     (statusLoad),
    .statusValue    (statusValue),
    .bsrLoad        (bsrLoad),
    .bsrValue       (bsrValue),
    .gieHighSet     (gieHighSet),
    .gieLowSet      (gieLowSet),
    .stackDepth     (stackDepth),
    .stackOverflow  (stackOverflow),
    .stackUnderflow (stackUnderflow)
  );

endmodule

// File: rtl/returnUnit_chk.sv
module returnUnit_chk
  import returnUnitPkg::*;
#(
  parameter int DEPTH   = 31,
  localparam int PTR_W  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             instrValid,
  input logic [15:0]      instrWord,
  input logic             intEntry,
  input logic             busy,
  input logic             pcLoad,
  input logic             wLoad,
  input logic [7:0]       wValue,
  input logic             statusLoad,
  input logic             bsrLoad,
  input logic             gieHighSet,
  input logic             gieLowSet,
  input logic [PTR_W-1:0] stackDepth,
  input logic             stackOverflow,
  input logic             stackUnderflow
);

  logic offered;
  assign offered = instrValid && !busy && !intEntry;

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (offered && (isIntReturn(instrWord) || isLitReturn(instrWord))) |=> (busy && pcLoad));

  p_busy_ignores_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !pcLoad);

  p_literal_w_r2: assert property (@(posedge clk) disable iff (!rstN)
    (offered && isLitReturn(instrWord)) |=>
      (wLoad && wValue == $past(instrWord[7:0]) && !statusLoad && !bsrLoad && !gieHighSet && !gieLowSet));

  p_no_restore_r4: assert property (@(posedge clk) disable iff (!rstN)
    (offered && isIntReturn(instrWord) && !instrWord[0]) |=> (!wLoad && !statusLoad && !bsrLoad));

  p_restore_all_r4: assert property (@(posedge clk) disable iff (!rstN)
    (offered && instrWord == 16'h0011) |=> (wLoad && statusLoad && bsrLoad));

  p_gie_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gieHighSet, gieLowSet}));

  p_entry_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intEntry && !busy) |=> !pcLoad);

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= PTR_W'(DEPTH));

  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    stackOverflow |=> stackOverflow);

  p_underflow_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    stackUnderflow |=> stackUnderflow);

endmodule

bind returnUnit returnUnit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .instrValid     (instrValid),
  .instrWord      (instrWord),
  .intEntry       (intEntry),
  .busy           (busy),
  .pcLoad         (pcLoad),
  .wLoad          (wLoad),
  .wValue         (wValue),
  .statusLoad     (statusLoad),
  .bsrLoad        (bsrLoad),
  .gieHighSet     (gieHighSet),
  .gieLowSet      (gieLowSet),
  .stackDepth     (stackDepth),
  .stackOverflow  (stackOverflow),
  .stackUnderflow (stackUnderflow)
);

// File: tb/returnUnit_bench.sv
module returnUnit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 21;
  localparam int DEPTH = 31;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        intEntry = 1'b0;
  logic        intEntryHigh = 1'b0;
  logic [PC_W-1:0] intReturnAddr = '0;
  logic [7:0]  wCur = '0;
  logic [4:0]  statusCur = '0;
  logic [3:0]  bsrCur = '0;
  logic        busy, pcLoad, wLoad, statusLoad, bsrLoad, gieHighSet, gieLowSet;
  logic [PC_W-1:0] pcValue;
  logic [7:0]  wValue;
  logic [4:0]  statusValue;
  logic [3:0]  bsrValue;
  logic [4:0]  stackDepth;
  logic        stackOverflow, stackUnderflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mDepth;
  int mStack [DEPTH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  returnUnit u_returnUnit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .intEntry(intEntry), .intEntryHigh(intEntryHigh), .intReturnAddr(intReturnAddr),
    .wCur(wCur), .statusCur(statusCur), .bsrCur(bsrCur), .busy(busy),
    .pcLoad(pcLoad), .pcValue(pcValue), .wLoad(wLoad), .wValue(wValue),
    .statusLoad(statusLoad), .statusValue(statusValue), .bsrLoad(bsrLoad),
    .bsrValue(bsrValue), .gieHighSet(gieHighSet), .gieLowSet(gieLowSet),
    .stackDepth(stackDepth), .stackOverflow(stackOverflow), .stackUnderflow(stackUnderflow)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    instrValid = 1'b0;
    intEntry = 1'b0;
    step();
    rstN = 1'b1;
    step();
    mDepth = 0;
  endtask

  task automatic entry(input int addr, input bit hi, input int w, input int st, input int bsr);
    intEntry = 1'b1; intEntryHigh = hi; intReturnAddr = PC_W'(addr);
    wCur = 8'(w); statusCur = 5'(st); bsrCur = 4'(bsr);
    step();
    intEntry = 1'b0;
    if (mDepth < DEPTH) begin mStack[mDepth] = addr; mDepth++; end
  endtask

  // offer one instruction; results stay visible until step() is called
  task automatic issue(input logic [15:0] word);
    instrValid = 1'b1; instrWord = word;
    step();
    instrValid = 1'b0;
  endtask

  function automatic int modelPop();
    if (mDepth == 0) return 0;
    mDepth--;
    return mStack[mDepth];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp;
    doReset();
    // R12 reset state
    check({busy, pcLoad, wLoad, statusLoad, bsrLoad, gieHighSet, gieLowSet} == 0, "R12 strobes", 
          {busy, pcLoad, wLoad, statusLoad, bsrLoad, gieHighSet, gieLowSet}, 0);
    check(stackDepth == 0 && !stackOverflow && !stackUnderflow, "R12 stack",
          {stackDepth, stackOverflow, stackUnderflow}, 0);

    // R2 literal sweep over all 256 operands
    for (int k = 0; k < 256; k++) begin
      entry((k * 37 + 5) & 16'hFFFF, 1'b0, 0, 0, 0);
      issue(16'h0C00 | 16'(k));
      exp = modelPop();
      check(pcLoad && pcValue == PC_W'(exp), "R2 pc", pcValue, exp);
      check(wLoad && wValue == 8'(k), "R2 literal", wValue, k);
      check(!statusLoad && !bsrLoad && !gieHighSet && !gieLowSet, "R2 side",
            {statusLoad, bsrLoad, gieHighSet, gieLowSet}, 0);
      check(busy, "R3 busy", busy, 1);
      step();
    end

    // R4/R6 fast-restore and level sweep
    for (int i = 0; i < 64; i++) begin
      bit hi, s;
      hi = i[0]; s = i[1];
      entry(1000 + i, hi, i * 7 + 3, i + 1, i + 2);
      issue(16'h0010 | 16'(s));
      exp = modelPop();
      check(pcLoad && pcValue == PC_W'(exp), "R1 pc", pcValue, exp);
      check(stackDepth == 5'(mDepth), "R1 depth", stackDepth, mDepth);
      if (s) begin
        check(wLoad && statusLoad && bsrLoad, "R4 strobes", {wLoad, statusLoad, bsrLoad}, 7);
        check(wValue == 8'(i * 7 + 3) && statusValue == 5'(i + 1) && bsrValue == 4'(i + 2),
              "R4 values", {wValue, statusValue, bsrValue}, {8'(i * 7 + 3), 5'(i + 1), 4'(i + 2)});
      end else begin
        check(!wLoad && !statusLoad && !bsrLoad, "R4 no restore", {wLoad, statusLoad, bsrLoad}, 0);
      end
      check(gieHighSet == hi && gieLowSet == !hi, "R6 level", {gieHighSet, gieLowSet}, {hi, !hi});
      step();
    end

    // R6 nesting, R5 shadow retention
    entry(500, 1'b0, 8'h11, 5'h01, 4'h1);
    entry(600, 1'b1, 8'h22, 5'h02, 4'h2);
    issue(16'h0011);
    check(pcValue == 600 && gieHighSet && !gieLowSet, "R6 high exit", {pcValue, gieHighSet}, {21'd600, 1'b1});
    check(wValue == 8'h22 && statusValue == 5'h02 && bsrValue == 4'h2, "R5 captured", wValue, 8'h22);
    step();
    issue(16'h0011);
    check(pcValue == 500 && gieLowSet && !gieHighSet, "R6 low exit", {pcValue, gieLowSet}, {21'd500, 1'b1});
    check(wValue == 8'h22 && statusValue == 5'h02 && bsrValue == 4'h2, "R5 retained", wValue, 8'h22);
    step();
    mDepth = 0;

    // R3 instruction held into busy cycle is ignored
    entry(700, 1'b0, 0, 0, 0);
    entry(701, 1'b0, 0, 0, 0);
    instrValid = 1'b1; instrWord = 16'h0C55;
    step();
    check(pcLoad && pcValue == 701 && busy, "R3 first", pcValue, 701);
    step();
    instrValid = 1'b0;
    check(!pcLoad && !busy && stackDepth == 1, "R3 ignored", {pcLoad, stackDepth}, 1);
    issue(16'h0C00);
    check(pcValue == 700, "R3 stack intact", pcValue, 700);
    step();

    // R10 entry and return in the same cycle; entry during busy cycle
    entry(800, 1'b0, 0, 0, 0);
    intEntry = 1'b1; intEntryHigh = 1'b0; intReturnAddr = 801;
    issue(16'h0C12);
    intEntry = 1'b0;
    check(!pcLoad && !wLoad && !busy && stackDepth == 2, "R10 return dropped", {pcLoad, stackDepth}, 2);
    issue(16'h0C13);
    check(pcValue == 801 && wValue == 8'h13, "R10 entry kept", pcValue, 801);
    intEntry = 1'b1; intReturnAddr = 802;
    step();
    intEntry = 1'b0;
    check(stackDepth == 2, "R10 entry in busy", stackDepth, 2);
    issue(16'h0C00);
    check(pcValue == 802, "R10 busy push", pcValue, 802);
    step();
    issue(16'h0C00);
    check(pcValue == 800 && stackDepth == 0, "R7 order", pcValue, 800);
    step();

    // R7/R8/R9 fill, overflow, drain, underflow
    doReset();
    for (int i = 0; i < DEPTH; i++) entry(2000 + i * 3, 1'b0, 0, 0, 0);
    check(stackDepth == 5'(DEPTH) && !stackOverflow, "R7 full", stackDepth, DEPTH);
    entry(9999, 1'b0, 0, 0, 0);
    check(stackOverflow && stackDepth == 5'(DEPTH), "R8 overflow", {stackOverflow, stackDepth}, {1'b1, 5'(DEPTH)});
    for (int i = DEPTH - 1; i >= 0; i--) begin
      issue(16'h0C00);
      check(pcValue == PC_W'(2000 + i * 3), "R7 lifo", pcValue, 2000 + i * 3);
      check(stackDepth == 5'(i), "R7 depth", stackDepth, i);
      step();
    end
    check(stackOverflow && !stackUnderflow, "R8 sticky", {stackOverflow, stackUnderflow}, 2);
    issue(16'h0010);
    check(pcLoad && pcValue == 0 && stackUnderflow && stackDepth == 0, "R9 underflow",
          {pcValue, stackUnderflow}, 1);
    step();
    check(stackUnderflow, "R9 sticky", stackUnderflow, 1);

    // R11 every other word with upper nibble zero has no effect
    doReset();
    entry(3000, 1'b0, 0, 0, 0);
    for (int w = 0; w < 4096; w++) begin
      if (w == 16'h0010 || w == 16'h0011 || (w >> 8) == 8'h0C) continue;
      issue(16'(w));
      check(!pcLoad && !busy && !wLoad && !gieHighSet && !gieLowSet, "R11 ignored", w, 0);
    end
    check(stackDepth == 1 && !stackUnderflow, "R11 stack", stackDepth, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule